// File: doc/BRIEF.md
# Chip Erase Sequencer

This block carries out a whole-array erase without any help from the host once it has been triggered. A single `start` pulse from the command decoder launches the run. The block first writes zeros to every word of each unprotected sector and checks that each word reads back as zero. It then walks the sectors in ascending order. Each unprotected sector is erased one word at a time to all ones, and every word is verified after it is written. Sectors flagged in `prot_mask` are skipped in both phases, so their contents survive.

The storage is a simple synchronous array model that sits inside the block. Reset fills the array with ones, which is the erased value. Outside a run, a host program write clears bits by a bitwise AND with the stored word. A sector flagged in `wear_mask` models worn cells that no longer change state, so writes to that sector have no effect. While a run is active, reads return a status word instead of array data. The status carries a polling bit, a toggle bit, an error bit and a sector toggle bit, and `busy` acts as the ready/busy pin. A verify mismatch stops the run in an error state that only reset clears. Reset also aborts a run at any point.

Top module: `erase_seq`

## Requirements
- R1: After reset `busy` is 0, `rd_data` is 0, and every array word reads all ones.
- R2: While idle, a host write (`wr_en`) stores the bitwise AND of `wr_data` and the current word. Writing 8'hF0 and then 8'h3C to the same word leaves 8'h30.
- R3: A `start` pulse while idle raises `busy` on the next cycle. A clean run keeps `busy` high for exactly 4 × (words in unprotected sectors) + 2 × (protected sectors) cycles. After that, `busy` is 0 and reads return array data one cycle after `rd_en`.
- R4: After a clean run, every word in an unprotected sector reads all ones, whatever it held before.
- R5: The sequencer never writes a sector whose `prot_mask` bit is set, so its contents are unchanged after the run.
- R6: While `busy` is high, further `start` pulses and host writes have no effect. The run length is unchanged and the addressed word keeps its value.
- R7: A read while `busy` is high returns a status word. Bit 7 is 0. Bit 6 inverts on every such read. Bit 5 is the error flag. All other bits apart from bit 2 are 0.
- R8: In the status word, bit 2 inverts only on status reads whose address lies in the sector being erased. Status reads of any other sector leave it unchanged.
- R9: If the preprogram verify fails, the block enters an error state. A sector in `wear_mask` that still holds ones triggers this. In the error state `busy` stays high and status bit 5 reads 1 until reset.
- R10: An erase verify failure has the same effect. A worn sector that passed preprogram triggers this.
- R11: Taking `rst_n` low during a run returns `busy` to 0. Afterwards reads return array data, and a new run completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; aborts a run and fills the array with ones |
| start | input | 1 | One-cycle trigger for a chip erase run |
| prot_mask | input | SECTORS | One bit per sector; 1 keeps the sector untouched |
| wear_mask | input | SECTORS | One bit per sector; 1 makes its cells ignore writes (array model) |
| wr_en | input | 1 | Host program write strobe, honoured only while idle |
| wr_addr | input | SEC_W+WRD_W | Host write word address, sector in the upper bits |
| wr_data | input | DATA_W | Host write data, ANDed into the word |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | SEC_W+WRD_W | Read word address, sector in the upper bits |
| rd_data | output | DATA_W | Array data when idle, status word when busy; registered |
| busy | output | 1 | High while a run is active or stopped in error |

## Verification
The checker evaluates several properties on every cycle. A start seen while idle must be followed by busy. No array write may land in a protected sector during a run. The error state must persist and keep busy high. Every status read must show bit 7 low, bit 6 inverted between back-to-back status reads, and bit 5 set once in error.

Some behaviour only the directed scenarios can show. These are the exact run length, the array contents after a run, and that writes and start pulses during a run are ignored. They also cover the sector-sensitive bit 2 pattern, the two failure paths, and abort by reset.

// File: rtl/es_pkg.sv
// Shared types and status bit positions for the chip erase sequencer.
// Assumes a data width of at least 8 bits so every status bit position exists.
package es_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_W,
        ST_PRE_V,
        ST_ERA_W,
        ST_ERA_V,
        ST_FAIL
    } es_state_t;

    typedef enum logic {
        OP_PROG = 1'b0,
        OP_FILL = 1'b1
    } es_op_t;

    localparam int STAT_POLL  = 7;
    localparam int STAT_TOG   = 6;
    localparam int STAT_ERR   = 5;
    localparam int STAT_SECT  = 2;
endpackage

// File: rtl/es_array.sv
// Array model: a flat word store with one write port and two read ports.
// OP_PROG clears bits (AND with write data). OP_FILL sets a word to all ones.
// Writes into a sector flagged in wear_mask are dropped, which models worn cells.
// Assumes SECTORS and SECTOR_WORDS are powers of two, each at least 2.
module es_array
    import es_pkg::*;
#(
    parameter  int DATA_W       = 8,
    parameter  int SECTORS      = 4,
    parameter  int SECTOR_WORDS = 8,
    localparam int SEC_W        = $clog2(SECTORS),
    localparam int WRD_W        = $clog2(SECTOR_WORDS),
    localparam int AW           = SEC_W + WRD_W,
    localparam int WORDS        = SECTORS * SECTOR_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  es_op_t            op,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SECTORS-1:0] wear_mask,
    input  logic [AW-1:0]     va_addr,
    output logic [DATA_W-1:0] va_data,
    input  logic [AW-1:0]     rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [SEC_W-1:0]  wsec;
    logic              blocked;

    assign wsec    = waddr[AW-1 -: SEC_W];
    assign blocked = wear_mask[wsec];

    // Storage update: fill on reset, then program or erase one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (we && !blocked) begin
            mem[waddr] <= (op == OP_FILL) ? '1 : (mem[waddr] & wdata);
        end
    end

    // Combinational read ports for the verify step and the host read path.
    assign va_data = mem[va_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/es_ctrl.sv
// Run controller: walks every word of every sector twice.
// The first pass writes zeros and verifies them. The second pass writes ones and verifies them.
// A protected sector costs one cycle per pass and is never written.
// A verify mismatch parks the controller in ST_FAIL until reset.
module es_ctrl
    import es_pkg::*;
#(
    parameter  int DATA_W       = 8,
    parameter  int SECTORS      = 4,
    parameter  int SECTOR_WORDS = 8,
    localparam int SEC_W        = $clog2(SECTORS),
    localparam int WRD_W        = $clog2(SECTOR_WORDS),
    localparam int AW           = SEC_W + WRD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SECTORS-1:0] prot_mask,
    input  logic [DATA_W-1:0]  vdata,
    output logic [AW-1:0]      addr,
    output logic               we,
    output es_op_t             op,
    output logic               busy,
    output logic               fail,
    output logic               erasing,
    output logic [SEC_W-1:0]   cur_sec
);
    localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SECTORS - 1);
    localparam logic [WRD_W-1:0] LAST_WRD = WRD_W'(SECTOR_WORDS - 1);

    es_state_t        state, st_n;
    logic [SEC_W-1:0] sec, sec_n;
    logic [WRD_W-1:0] wrd, wrd_n;
    logic             prot_here, sec_last, wrd_last, pre_phase, v_ok;

    assign prot_here = prot_mask[sec];
    assign sec_last  = (sec == LAST_SEC);
    assign wrd_last  = (wrd == LAST_WRD);
    assign pre_phase = (state == ST_PRE_W) || (state == ST_PRE_V);
    assign v_ok      = pre_phase ? (vdata == '0) : (vdata == '1);

    // Next state and next address for the two-pass walk.
    always_comb begin
        st_n  = state;
        sec_n = sec;
        wrd_n = wrd;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    st_n  = ST_PRE_W;
                    sec_n = '0;
                    wrd_n = '0;
                end
            end
            ST_PRE_W, ST_ERA_W: begin
                if (prot_here) begin
                    wrd_n = '0;
                    sec_n = sec_last ? '0 : sec + 1'b1;
                    if (sec_last) st_n = pre_phase ? ST_ERA_W : ST_IDLE;
                end else begin
                    st_n = pre_phase ? ST_PRE_V : ST_ERA_V;
                end
            end
            ST_PRE_V, ST_ERA_V: begin
                if (!v_ok) begin
                    st_n = ST_FAIL;
                end else if (wrd_last) begin
                    wrd_n = '0;
                    sec_n = sec_last ? '0 : sec + 1'b1;
                    if (sec_last) st_n = pre_phase ? ST_ERA_W : ST_IDLE;
                    else          st_n = pre_phase ? ST_PRE_W : ST_ERA_W;
                end else begin
                    wrd_n = wrd + 1'b1;
                    st_n  = pre_phase ? ST_PRE_W : ST_ERA_W;
                end
            end
            ST_FAIL: st_n = ST_FAIL;
            default: st_n = ST_IDLE;
        endcase
    end

    // State and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sec   <= '0;
            wrd   <= '0;
        end else begin
            state <= st_n;
            sec   <= sec_n;
            wrd   <= wrd_n;
        end
    end

    assign addr    = {sec, wrd};
    assign we      = ((state == ST_PRE_W) || (state == ST_ERA_W)) && !prot_here;
    assign op      = (state == ST_ERA_W) ? OP_FILL : OP_PROG;
    assign busy    = (state != ST_IDLE);
    assign fail    = (state == ST_FAIL);
    assign erasing = (state == ST_ERA_W) || (state == ST_ERA_V);
    assign cur_sec = sec;
endmodule

// File: rtl/es_status.sv
// Read path: a registered output that carries array data while idle and a status word while busy.
// The toggle bits advance only on status reads. The sector bit advances only when the read
// address falls in the sector being erased.
module es_status
    import es_pkg::*;
#(
    parameter  int DATA_W       = 8,
    parameter  int SECTORS      = 4,
    parameter  int SECTOR_WORDS = 8,
    localparam int SEC_W        = $clog2(SECTORS),
    localparam int WRD_W        = $clog2(SECTOR_WORDS),
    localparam int AW           = SEC_W + WRD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic              busy,
    input  logic              fail,
    input  logic              erasing,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic              tog, stog;
    logic [DATA_W-1:0] stat;
    logic              hit_sec;

    assign hit_sec = erasing && (rd_addr[AW-1 -: SEC_W] == cur_sec);

    // Status word assembly; unused bits read zero.
    always_comb begin
        stat            = '0;
        stat[STAT_POLL] = 1'b0;
        stat[STAT_TOG]  = tog;
        stat[STAT_ERR]  = fail;
        stat[STAT_SECT] = stog;
    end

    // Output register and toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            tog     <= 1'b0;
            stog    <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rd_data <= stat;
                tog     <= ~tog;
                if (hit_sec) stog <= ~stog;
            end else begin
                rd_data <= arr_data;
            end
        end
    end
endmodule

// File: rtl/erase_seq.sv
// Chip erase sequencer top: joins the controller, the array model and the read path.
// Host writes reach the array only while idle. During a run the controller owns the write port.
module erase_seq
    import es_pkg::*;
#(
    parameter  int DATA_W       = 8,
    parameter  int SECTORS      = 4,
    parameter  int SECTOR_WORDS = 8,
    localparam int SEC_W        = $clog2(SECTORS),
    localparam int WRD_W        = $clog2(SECTOR_WORDS),
    localparam int AW           = SEC_W + WRD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SECTORS-1:0] prot_mask,
    input  logic [SECTORS-1:0] wear_mask,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               busy
);
    logic [AW-1:0]     c_addr;
    logic              c_we, c_busy, c_fail, c_erasing;
    es_op_t            c_op;
    logic [SEC_W-1:0]  c_sec;
    logic [DATA_W-1:0] va_data, rb_data;
    logic              arr_we;
    es_op_t            arr_op;
    logic [AW-1:0]     arr_waddr;
    logic [DATA_W-1:0] arr_wdata;
    logic [SEC_W-1:0]  arr_wsec;

    es_ctrl #(.DATA_W(DATA_W), .SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .prot_mask(prot_mask),
        .vdata(va_data), .addr(c_addr), .we(c_we), .op(c_op),
        .busy(c_busy), .fail(c_fail), .erasing(c_erasing), .cur_sec(c_sec)
    );

    // Write port ownership: controller while running, host while idle.
    assign arr_we    = c_busy ? c_we   : wr_en;
    assign arr_op    = c_busy ? c_op   : OP_PROG;
    assign arr_waddr = c_busy ? c_addr : wr_addr;
    assign arr_wdata = c_busy ? '0     : wr_data;
    assign arr_wsec  = arr_waddr[AW-1 -: SEC_W];

    es_array #(.DATA_W(DATA_W), .SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .op(arr_op), .waddr(arr_waddr),
        .wdata(arr_wdata), .wear_mask(wear_mask), .va_addr(c_addr), .va_data(va_data),
        .rb_addr(rd_addr), .rb_data(rb_data)
    );

    es_status #(.DATA_W(DATA_W), .SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)) u_stat (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .busy(c_busy),
        .fail(c_fail), .erasing(c_erasing), .cur_sec(c_sec), .arr_data(rb_data),
        .rd_data(rd_data)
    );

    assign busy = c_busy;
endmodule

// File: rtl/es_check.sv
// Protocol checker for erase_seq, attached by bind. It watches ports and internal controls.
module es_check
    import es_pkg::*;
#(
    parameter  int DATA_W  = 8,
    parameter  int SECTORS = 4,
    localparam int SEC_W   = $clog2(SECTORS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               fail,
    input logic               rd_en,
    input logic [DATA_W-1:0]  rd_data,
    input logic               arr_we,
    input logic [SEC_W-1:0]   arr_wsec,
    input logic [SECTORS-1:0] prot_mask
);
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r5_no_prot_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && arr_we) |-> !prot_mask[arr_wsec]);

    a_r6_start_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !fail) |=> busy);

    a_r7_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> !rd_data[STAT_POLL]);

    a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) ##1 (rd_en && busy) |=> (rd_data[STAT_TOG] != $past(rd_data[STAT_TOG])));

    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (fail && busy));

    a_r9_fail_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && fail) |=> rd_data[STAT_ERR]);
endmodule

bind erase_seq es_check #(.DATA_W(DATA_W), .SECTORS(SECTORS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .fail(c_fail),
    .rd_en(rd_en), .rd_data(rd_data), .arr_we(arr_we), .arr_wsec(arr_wsec),
    .prot_mask(prot_mask)
);

// File: tb/sim_erase_seq.sv
`timescale 1ns/1ps
module sim_erase_seq;
    localparam int DW = 8;
    localparam int NS = 4;
    localparam int SW = 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NS-1:0] prot_mask = '0;
    logic [NS-1:0] wear_mask = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    erase_seq #(.DATA_W(DW), .SECTORS(NS), .SECTOR_WORDS(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .prot_mask(prot_mask),
        .wear_mask(wear_mask), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0; prot_mask = '0; wear_mask = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [DW-1:0] d);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic run_erase(output int n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        hw_reset();
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
        do_read(7, d);
        check(d == 8'hFF, "R1 erased word after reset", d, 8'hFF);
    endtask

    task automatic t_program_and();
        logic [DW-1:0] d;
        do_write(3, 8'hF0);
        do_write(3, 8'h3C);
        do_read(3, d);
        check(d == 8'h30, "R2 program is AND", d, 8'h30);
        do_write(9, 8'h55);
        do_read(9, d);
        check(d == 8'h55, "R2 single program", d, 8'h55);
    endtask

    task automatic t_full();
        logic [DW-1:0] d;
        int n;
        int bad;
        hw_reset();
        do_write(0, 8'h00);
        do_write(13, 8'h5A);
        do_write(31, 8'h0F);
        run_erase(n);
        check(n == 128, "R3 run length no protection", n, 128);
        check(busy == 1'b0, "R3 busy low after run", busy, 0);
        bad = 0;
        for (int a = 0; a < NS * SW; a++) begin
            do_read(a, d);
            if (d != 8'hFF) bad++;
        end
        check(bad == 0, "R4 all words erased", bad, 0);
    endtask

    task automatic t_protect();
        logic [DW-1:0] d;
        int n;
        hw_reset();
        for (int w = 0; w < SW; w++) do_write(16 + w, 8'hC0 | w);
        do_write(3, 8'h12);
        prot_mask = 4'b0100;
        run_erase(n);
        check(n == 98, "R3 run length one protected", n, 98);
        for (int w = 0; w < SW; w++) begin
            do_read(16 + w, d);
            check(d == (8'hC0 | w), "R5 protected word kept", d, 8'hC0 | w);
        end
        do_read(3, d);
        check(d == 8'hFF, "R4 unprotected word erased", d, 8'hFF);
    endtask

    task automatic t_ignore();
        logic [DW-1:0] d;
        int n;
        hw_reset();
        prot_mask = 4'b0001;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            n++;
            if (n == 10) begin
                start = 1'b1; wr_en = 1'b1; wr_addr = 5'd2; wr_data = 8'h00;
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; wr_en = 1'b0;
        check(n == 98, "R6 start during run ignored", n, 98);
        do_read(2, d);
        check(d == 8'hFF, "R6 write during run ignored", d, 8'hFF);
    endtask

    task automatic t_status();
        logic [DW-1:0] x1, x2, x3, x4;
        int n;
        hw_reset();
        prot_mask = 4'b1110;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (21) @(negedge clk);
        do_read(0, x1);
        do_read(1, x2);
        do_read(16, x3);
        do_read(17, x4);
        check(busy == 1'b1, "R7 still busy during reads", busy, 1);
        check(x1[7] == 1'b0, "R7 poll bit low", x1[7], 0);
        check(x1[5] == 1'b0, "R7 error bit clear", x1[5], 0);
        check((x1 & 8'h9B) == 8'h00, "R7 unused bits zero", x1, x1 & 8'h64);
        check(x1[6] != x2[6], "R7 toggle 1-2", x2[6], ~x1[6]);
        check(x2[6] != x3[6], "R7 toggle 2-3", x3[6], ~x2[6]);
        check(x3[6] != x4[6], "R7 toggle 3-4", x4[6], ~x3[6]);
        check(x1[2] != x2[2], "R8 sector bit toggles in erased sector", x2[2], ~x1[2]);
        check(x3[2] == x4[2], "R8 sector bit steady for other sector", x4[2], x3[2]);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check(busy == 1'b0, "R3 run ends after status reads", busy, 0);
    endtask

    task automatic t_fail_pre();
        logic [DW-1:0] d;
        hw_reset();
        wear_mask = 4'b0010;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        check(busy == 1'b1, "R9 busy held after preprogram failure", busy, 1);
        do_read(0, d);
        check(d[5] == 1'b1, "R9 error bit after preprogram failure", d[5], 1);
        hw_reset();
        check(busy == 1'b0, "R9 reset clears error state", busy, 0);
    endtask

    task automatic t_fail_erase();
        logic [DW-1:0] d;
        hw_reset();
        for (int w = 0; w < SW; w++) do_write(8 + w, 8'h00);
        wear_mask = 4'b0010;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        check(busy == 1'b1, "R10 busy held after erase failure", busy, 1);
        do_read(9, d);
        check(d[5] == 1'b1, "R10 error bit after erase failure", d[5], 1);
        check(d[7] == 1'b0, "R10 poll bit low in error", d[7], 0);
        hw_reset();
    endtask

    task automatic t_abort();
        logic [DW-1:0] d;
        int n;
        hw_reset();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R11 reset aborts run", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(4, d);
        check(d == 8'hFF, "R11 array data after abort", d, 8'hFF);
        run_erase(n);
        check(n == 128, "R11 fresh run after abort", n, 128);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_program_and();
        t_full();
        t_protect();
        t_ignore();
        t_status();
        t_fail_pre();
        t_fail_erase();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule